// File: doc/BRIEF.md
# Row Program Holding Latch Buffer

This block stages the data for one program operation on the nonvolatile code array. Table writes never reach the array; they land in a bank of holding latches, one latch per instruction word, each split into a 16-bit low lane and an 8-bit high lane. The low bits of the table-write address pick the latch, so the bank can be filled in any order, and word or byte writes can update part of an entry.

When the program controller asks for an operation, the buffer streams its contents out one latch per clock, starting at latch 0, together with the destination address of each beat. A full-row operation sends every latch to a row-aligned destination. A word-pair operation sends latches 0 and 1 to an even/odd pair. A configuration write sends only the low lane of latch 0. The controller can also read any latch and its written flag through an index port, and can clear all written flags once an operation has finished. Latches keep their old contents until they are written again.

Top module: `prog_row_latch_buf`

## Requirements
- R1: After reset no stream is active (`out_valid` low) and every latch reads back with its written flag clear.
- R2: A word-mode table write (`tw_byte`=0) selects latch `tw_addr[7:1]` and ignores `tw_addr[0]`. The low lane (`tw_high`=0) loads latch bits 15:0 from `tw_data`. The high lane (`tw_high`=1) loads latch bits 23:16 from `tw_data[7:0]` and ignores `tw_data[15:8]`. Latches can be loaded in any order.
- R3: In byte mode (`tw_byte`=1), `tw_addr[0]` selects the byte and only `tw_data[7:0]` is used. With the low lane, select 0 loads bits 7:0 and select 1 loads bits 15:8. With the high lane, select 0 loads bits 23:16. A high-lane byte write with select 1 targets a byte that does not exist, and it changes neither the latch nor its written flag.
- R4: Every accepted write sets the written flag of its latch. A `flag_clr` pulse clears all flags and leaves the latch contents unchanged.
- R5: `rd_word` and `rd_written` show the latch chosen by `rd_idx` one clock after it is presented.
- R6: `op_kind`=2'b10 (row) streams 128 beats: beat i carries latch i, and its address is `op_addr` with bits 7:0 cleared, plus 2*i.
- R7: `op_kind`=2'b01 (word pair) streams 2 beats: latches 0 and 1, sent to `op_addr` with bits 1:0 cleared and to that address plus 2.
- R8: `op_kind`=2'b00 (configuration) streams 1 beat. The address is `op_addr` with bit 0 cleared, and the data is latch 0 bits 15:0 with bits 23:16 forced to zero.
- R9: The first beat appears in the clock after the `op_start` edge, and beats follow on consecutive clocks. `out_last` is high on the final beat only, and `out_valid` falls in the clock after it.
- R10: While a stream is active, `op_start` and table writes are ignored.
- R11: `op_start` with `op_kind`=2'b11 is ignored and no stream begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_valid | input | 1 | Table write strobe |
| tw_high | input | 1 | Lane select: 0 low lane, 1 high lane |
| tw_byte | input | 1 | 1 selects byte mode |
| tw_addr | input | 8 | Table write address: bits 7:1 pick the latch, bit 0 picks the byte |
| tw_data | input | 16 | Table write data |
| flag_clr | input | 1 | Clear all written flags |
| rd_idx | input | 7 | Latch index for readback |
| rd_word | output | 24 | Contents of the indexed latch, registered |
| rd_written | output | 1 | Written flag of the indexed latch, registered |
| op_start | input | 1 | Start a program stream |
| op_kind | input | 2 | 00 config, 01 word pair, 10 row, 11 reserved |
| op_addr | input | 24 | Destination address given by the controller |
| out_valid | output | 1 | Stream beat valid |
| out_addr | output | 24 | Destination address of the beat |
| out_data | output | 24 | Data of the beat |
| out_last | output | 1 | Final beat of the stream |

## Verification
The assertions assume that the controller never starts an operation whose beats would carry latches that were never written. The stimulus therefore fills the whole bank before the first start, and every later operation reuses latches that are already defined. The assertions also assume that `flag_clr` and a table write never fall in the same clock. The stimulus keeps the two apart, and it keeps readback sweeps away from cycles that write, so every flag it observes belongs to a settled state. Stimulus inside an active stream is deliberate, because it checks that such input is ignored.

// File: rtl/flash_latch_pkg.sv
package flash_latch_pkg;
    typedef enum logic [1:0] {
        OP_CFG  = 2'b00,
        OP_PAIR = 2'b01,
        OP_ROW  = 2'b10,
        OP_RSVD = 2'b11
    } op_kind_e;
endpackage

// File: rtl/hl_write_decode.sv
module hl_write_decode #(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int IDX_W  = 7,
    parameter int WORD_W = LO_W + HI_W
) (
    input  logic              tw_valid,
    input  logic              tw_high,
    input  logic              tw_byte,
    input  logic [IDX_W:0]    tw_addr,
    input  logic [LO_W-1:0]   tw_data,
    input  logic              blocked,
    input  logic [WORD_W-1:0] old_word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_word
);
    localparam int BYTE = 8;

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = tw_addr[IDX_W:1];
        wr_word = old_word;
        if (tw_valid && !blocked) begin
            if (!tw_byte) begin
                wr_en = 1'b1;
                if (!tw_high) wr_word[LO_W-1:0]      = tw_data;
                else          wr_word[WORD_W-1:LO_W] = tw_data[HI_W-1:0];
            end else if (!tw_high) begin
                wr_en = 1'b1;
                if (tw_addr[0]) wr_word[BYTE +: BYTE] = tw_data[BYTE-1:0];
                else            wr_word[0 +: BYTE]    = tw_data[BYTE-1:0];
            end else if (!tw_addr[0]) begin
                wr_en = 1'b1;
                wr_word[WORD_W-1:LO_W] = tw_data[HI_W-1:0];
            end
        end
    end
endmodule

// File: rtl/hl_latch_store.sv
module hl_latch_store #(
    parameter int LATCHES = 128,
    parameter int WORD_W  = 24,
    parameter int IDX_W   = $clog2(LATCHES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              flag_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  seq_idx,
    output logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] seq_word,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_written
);
    typedef struct packed {
        logic [LATCHES-1:0] written;
        logic [WORD_W-1:0]  rd_word;
        logic               rd_written;
    } st_t;

    logic [WORD_W-1:0] mem [LATCHES];
    logic [LATCHES-1:0] set_vec;
    st_t st_d, st_q;

    generate
        for (genvar g = 0; g < LATCHES; g++) begin : g_set
            assign set_vec[g] = wr_en && (wr_idx == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_word;
    end

    assign old_word = mem[wr_idx];
    assign seq_word = mem[seq_idx];

    always_comb begin
        st_d            = st_q;
        st_d.rd_word    = mem[rd_idx];
        st_d.rd_written = st_q.written[rd_idx];
        if (flag_clr) st_d.written = '0;
        st_d.written = st_d.written | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word    = st_q.rd_word;
    assign rd_written = st_q.rd_written;
endmodule

// File: rtl/hl_stream_seq.sv
module hl_stream_seq
    import flash_latch_pkg::*;
#(
    parameter int LATCHES = 128,
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = $clog2(LATCHES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              busy,
    output logic              last,
    output logic [IDX_W-1:0]  idx,
    output op_kind_e          kind,
    output logic [ADDR_W-1:0] beat_addr
);
    localparam logic [ADDR_W-1:0] ROW_MASK  = ~((ADDR_W'(1) << (IDX_W + 1)) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] PAIR_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] CFG_MASK  = ~ADDR_W'(1);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last_idx;
        op_kind_e          kind;
        logic [ADDR_W-1:0] base;
    } st_t;

    st_t st_d, st_q;
    op_kind_e req_kind;

    assign req_kind = op_kind_e'(op_kind);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == st_q.last_idx) st_d.busy = 1'b0;
            else                           st_d.idx  = st_q.idx + IDX_W'(1);
        end else if (op_start && req_kind != OP_RSVD) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.kind = req_kind;
            case (req_kind)
                OP_ROW: begin
                    st_d.last_idx = IDX_W'(LATCHES - 1);
                    st_d.base     = op_addr & ROW_MASK;
                end
                OP_PAIR: begin
                    st_d.last_idx = IDX_W'(1);
                    st_d.base     = op_addr & PAIR_MASK;
                end
                default: begin
                    st_d.last_idx = '0;
                    st_d.base     = op_addr & CFG_MASK;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign idx       = st_q.idx;
    assign kind      = st_q.kind;
    assign last      = st_q.busy && (st_q.idx == st_q.last_idx);
    assign beat_addr = st_q.base + ADDR_W'({st_q.idx, 1'b0});
endmodule

// File: rtl/prog_row_latch_buf.sv
module prog_row_latch_buf
    import flash_latch_pkg::*;
#(
    parameter int LATCHES = 128,
    parameter int LO_W    = 16,
    parameter int HI_W    = 8,
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = $clog2(LATCHES),
    parameter int WORD_W  = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tw_valid,
    input  logic              tw_high,
    input  logic              tw_byte,
    input  logic [IDX_W:0]    tw_addr,
    input  logic [LO_W-1:0]   tw_data,
    input  logic              flag_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_written,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    logic              seq_busy;
    logic              seq_last;
    logic [IDX_W-1:0]  seq_idx;
    op_kind_e          seq_kind;
    logic [ADDR_W-1:0] seq_addr;
    logic [WORD_W-1:0] seq_word;
    logic [WORD_W-1:0] old_word;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;

    hl_write_decode #(.LO_W(LO_W), .HI_W(HI_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_dec (
        .tw_valid (tw_valid),
        .tw_high  (tw_high),
        .tw_byte  (tw_byte),
        .tw_addr  (tw_addr),
        .tw_data  (tw_data),
        .blocked  (seq_busy),
        .old_word (old_word),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word)
    );

    hl_latch_store #(.LATCHES(LATCHES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .flag_clr   (flag_clr),
        .rd_idx     (rd_idx),
        .seq_idx    (seq_idx),
        .old_word   (old_word),
        .seq_word   (seq_word),
        .rd_word    (rd_word),
        .rd_written (rd_written)
    );

    hl_stream_seq #(.LATCHES(LATCHES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .busy      (seq_busy),
        .last      (seq_last),
        .idx       (seq_idx),
        .kind      (seq_kind),
        .beat_addr (seq_addr)
    );

    assign out_valid = seq_busy;
    assign out_last  = seq_last;
    assign out_addr  = seq_addr;
    assign out_data  = (seq_kind == OP_CFG) ? {{HI_W{1'b0}}, seq_word[LO_W-1:0]} : seq_word;
endmodule

// File: rtl/prog_row_latch_buf_chk.sv
module prog_row_latch_buf_chk
    import flash_latch_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 24,
    parameter int LO_W   = 16,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_last,
    input logic [ADDR_W-1:0] out_addr,
    input logic [WORD_W-1:0] out_data,
    input op_kind_e          kind
);
    assert_last_inside_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_stream_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |=> !out_valid);

    assert_addr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid && (out_addr == $past(out_addr) + ADDR_W'(2)));

    assert_row_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && kind == OP_ROW |-> out_addr[IDX_W:0] == '0);

    assert_pair_two_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && kind == OP_PAIR |-> !out_last ##1 out_last);

    assert_cfg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && kind == OP_CFG |-> out_last && out_data[WORD_W-1:LO_W] == '0);
endmodule

bind prog_row_latch_buf prog_row_latch_buf_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LO_W(LO_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .kind      (seq_kind)
);

// File: tb/test_prog_row_latch_buf.sv
module test_prog_row_latch_buf;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tw_valid = 1'b0, tw_high = 1'b0, tw_byte = 1'b0;
    logic [7:0]  tw_addr = '0;
    logic [15:0] tw_data = '0;
    logic        flag_clr = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [23:0] rd_word;
    logic        rd_written;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [23:0] op_addr = '0;
    logic        out_valid, out_last;
    logic [23:0] out_addr, out_data;

    prog_row_latch_buf i_prog_row_latch_buf (.*);

    always #5 clk = ~clk;

    int nchk = 0, nerr = 0;
    string cur_req = "R1";

    // reference model
    logic [23:0] m_mem [N];
    logic [2:0]  m_kn  [N];
    bit          m_flag[N];
    bit          m_busy = 0;
    int          m_beat = 0, m_n = 0, m_kind = 0;
    logic [23:0] m_base = '0;
    logic [23:0] m_rd_word = '0;
    logic [2:0]  m_rd_kn = '0;
    bit          m_rd_wr = 0;

    initial for (int i = 0; i < N; i++) begin m_mem[i] = '0; m_kn[i] = '0; m_flag[i] = 0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            for (int i = 0; i < N; i++) m_flag[i] = 0;
        end else begin
            bit pre_busy;
            int ix;
            m_rd_word = m_mem[rd_idx];
            m_rd_kn   = m_kn[rd_idx];
            m_rd_wr   = m_flag[rd_idx];
            pre_busy  = m_busy;
            if (m_busy) begin
                if (m_beat == m_n - 1) m_busy = 0;
                else m_beat++;
            end else if (op_start && op_kind != 2'b11) begin
                m_busy = 1; m_beat = 0; m_kind = op_kind;
                if (op_kind == 2'b10) begin m_n = N; m_base = {op_addr[23:8], 8'h00}; end
                else if (op_kind == 2'b01) begin m_n = 2; m_base = {op_addr[23:2], 2'b00}; end
                else begin m_n = 1; m_base = {op_addr[23:1], 1'b0}; end
            end
            if (flag_clr) for (int i = 0; i < N; i++) m_flag[i] = 0;
            if (tw_valid && !pre_busy) begin
                ix = tw_addr[7:1];
                if (!tw_byte) begin
                    if (!tw_high) begin m_mem[ix][15:0] = tw_data; m_kn[ix] |= 3'b011; end
                    else begin m_mem[ix][23:16] = tw_data[7:0]; m_kn[ix] |= 3'b100; end
                    m_flag[ix] = 1;
                end else if (!tw_high) begin
                    if (tw_addr[0]) begin m_mem[ix][15:8] = tw_data[7:0]; m_kn[ix] |= 3'b010; end
                    else begin m_mem[ix][7:0] = tw_data[7:0]; m_kn[ix] |= 3'b001; end
                    m_flag[ix] = 1;
                end else if (!tw_addr[0]) begin
                    m_mem[ix][23:16] = tw_data[7:0]; m_kn[ix] |= 3'b100;
                    m_flag[ix] = 1;
                end
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            string sreq;
            logic [23:0] ed;
            chk(cur_req, {31'd0, out_valid}, {31'd0, m_busy});
            chk("R4", {31'd0, rd_written}, {31'd0, m_rd_wr});
            if (m_rd_kn == 3'b111) chk(cur_req, {8'd0, rd_word}, {8'd0, m_rd_word});
            if (m_busy) begin
                sreq = (m_kind == 2) ? "R6" : (m_kind == 1) ? "R7" : "R8";
                ed = (m_kind == 0) ? {8'h00, m_mem[m_beat][15:0]} : m_mem[m_beat];
                chk(sreq, {8'd0, out_addr}, {8'd0, m_base + 24'(2 * m_beat)});
                chk(sreq, {8'd0, out_data}, {8'd0, ed});
                chk("R9", {31'd0, out_last}, {31'd0, m_beat == m_n - 1});
            end
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic tw(input bit hi, input bit by, input logic [7:0] a, input logic [15:0] d);
        tw_valid = 1; tw_high = hi; tw_byte = by; tw_addr = a; tw_data = d;
        step();
        tw_valid = 0;
    endtask

    task automatic sweep();
        for (int i = 0; i < N; i++) begin rd_idx = 7'(i); step(); end
        step();
    endtask

    task automatic start(input logic [1:0] k, input logic [23:0] a, input int wait_n);
        op_start = 1; op_kind = k; op_addr = a;
        step();
        op_start = 0;
        for (int i = 0; i < wait_n; i++) step();
    endtask

    initial begin
        #1000000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        cur_req = "R1";
        sweep();

        // R2: scrambled-order word-mode fill, garbage in high-lane data[15:8]
        cur_req = "R2";
        for (int i = 0; i < N; i++) begin
            int ix;
            ix = (i * 37) % N;
            tw(0, 0, {7'(ix), 1'(i & 1)}, 16'hA000 ^ 16'(ix * 16'h0135));
            tw(1, 0, {7'(ix), 1'b0}, {8'hEE ^ 8'(ix), 8'h30 + 8'(ix)});
        end
        cur_req = "R5";
        sweep();

        // R6 row stream, with R10 ignored input mid-stream
        cur_req = "R6";
        op_start = 1; op_kind = 2'b10; op_addr = 24'h0223A6;
        step();
        op_start = 0;
        repeat (10) step();
        cur_req = "R10";
        tw(0, 0, {7'd3, 1'b0}, 16'hDEAD);
        op_start = 1; op_kind = 2'b01; op_addr = 24'h000010;
        step();
        op_start = 0;
        repeat (125) step();
        sweep();

        // R4 clear, R3 byte writes incl. phantom
        cur_req = "R4";
        flag_clr = 1; step(); flag_clr = 0;
        cur_req = "R3";
        tw(0, 1, {7'd5, 1'b0}, 16'hFF5A);
        tw(0, 1, {7'd5, 1'b1}, 16'h77C3);
        tw(1, 1, {7'd9, 1'b0}, 16'h1281);
        tw(1, 1, {7'd12, 1'b1}, 16'h0099);
        sweep();

        cur_req = "R7";
        start(2'b01, 24'h012347, 4);
        cur_req = "R8";
        start(2'b00, 24'h00F00B, 3);
        cur_req = "R11";
        start(2'b11, 24'h000000, 3);
        cur_req = "R9";
        start(2'b10, 24'h7FFFFF, 130);

        cur_req = "R4";
        flag_clr = 1; step(); flag_clr = 0;
        sweep();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule